// File: doc/BRIEF.md
# NAND bus timing sequencer

This block turns single-byte host requests into correctly timed cycles on an 8-bit asynchronous NAND flash bus. A request is one of four kinds: a command byte, an address byte, a data byte written to the device, or a data byte read from it. The block drives the chip enable, the command and address latch enables, the write and read strobes and the data bus. Each access passes through a setup phase, a strobe phase and a hold phase, followed by an optional wait before the device's ready/busy line is trusted again. Every phase length comes from a 32-bit timing register, with separate values for reads and for writes.

Around the sequencer sit a small configuration register, a control register and a status view. The configuration register can hold chip enable low across accesses, release write protection and enable the ready interrupt. The control register gives a soft reset and a write-one-to-clear for the interrupt flag. The status view reports the synchronised ready line. A flag latches every busy-to-ready transition of the device.

Top module: `nand_bus_seq`

## Requirements
- R1: After reset, chip enable and both strobes are high, both latch enables are low, `nand_wp_n` is low, `nand_dq_oe`, `busy`, `rd_valid` and `irq_flag` are low, and `stat_ready` is high while `nand_rdy` is high.
- R2: A request of kind 2'b00 (command) puts `req_wdata` on `nand_dq_o` with `nand_dq_oe` and `nand_cle` high and `nand_ale` low for the whole access.
- R3: A request of kind 2'b01 (address) behaves as in R2, but with `nand_ale` high and `nand_cle` low. Kind 2'b10 (data write) drives the bus with both latch enables low.
- R4: The timing register holds 4-bit fields, field i at bits [4i+3:4i]: 0 read setup, 1 read hold, 2 read strobe, 3 read ready-wait, 4 write setup, 5 write hold, 6 write strobe, 7 write ready-wait. On a write access, a setup, strobe or hold field of value v gives v+1 clocks, and `nand_we_n` is low for exactly the strobe count.
- R5: A request of kind 2'b11 (data read) holds `nand_re_n` low for the read strobe count, with the bus undriven. It captures `nand_dq_i` as `nand_re_n` rises, and it returns the byte on `rd_data` with a one-cycle `rd_valid` in the first cycle after `busy` falls.
- R6: After the hold phase, `busy` stays high for a further 2·n clocks, where n is the ready-wait field of the access direction. With n=0 no wait cycles are added.
- R7: `busy` is high from the clock edge that accepts a request until the hold and ready-wait phases end. Requests presented while `busy` is high are ignored.
- R8: While configuration bit 0 is set, `nand_ce_n` stays low, also between accesses.
- R9: `stat_ready` is the ready line after a two-stage synchroniser (1 = ready), and it reads 0 while `busy` is high.
- R10: A 0-to-1 transition of the synchronised ready line sets `irq_flag`. Writing 1 to control bit 1 clears it. `irq` is `irq_flag` gated by configuration bit 2.
- R11: Configuration bit 1 drives `nand_wp_n` high, which releases write protection.
- R12: Writing 1 to control bit 0 ends any access at once. At the next edge it returns the sequencer to idle and clears the configuration register and `irq_flag`. The timing register is kept.
- R13: Outside forced mode, `nand_ce_n` is low exactly during the setup, strobe and hold phases. The two strobes are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_kind | input | 2 | 00 command, 01 address, 10 data write, 11 data read |
| req_wdata | input | 8 | Byte for write-type requests |
| busy | output | 1 | Access in progress |
| rd_data | output | 8 | Byte captured by the last read |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |
| tim_we | input | 1 | Timing register write enable |
| tim_wdata | input | 32 | Timing register value |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 3 | Bit0 force CE, bit1 release WP, bit2 ready interrupt enable |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Bit0 soft reset, bit1 clear ready flag |
| stat_ready | output | 1 | Synchronised device ready, 0 while busy |
| irq_flag | output | 1 | Ready rising-edge flag |
| irq | output | 1 | Flag gated by interrupt enable |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_dq_o | output | 8 | Bus data out |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus data in |
| nand_rdy | input | 1 | Device ready/busy, 1 = ready |

## Verification
The strobe-width properties assume that the timing register is written only while `busy` is low, because a rewrite in the middle of an access would change the expected width. The bench therefore loads a new timing pattern only between accesses. A strobe cut short by a soft reset is exempt from the width check, so the bench aborts one long access in its strobe phase without breaking the properties. `nand_rdy` is treated as asynchronous, and the bench changes it only on falling clock edges, several cycles apart.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    K_CMD  = 2'b00,
    K_ADDR = 2'b01,
    K_DWR  = 2'b10,
    K_DRD  = 2'b11
  } req_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_PULSE,
    ST_HOLD,
    ST_RWAIT
  } seq_state_t;

  // Field slots inside the timing register; write group is read group + 4
  localparam int unsigned SLOT_SETUP = 0;
  localparam int unsigned SLOT_HOLD  = 1;
  localparam int unsigned SLOT_PULSE = 2;
  localparam int unsigned SLOT_WAIT  = 3;
  localparam int unsigned GRP_WRITE  = 4;

endpackage

// File: rtl/nand_phase_timer.sv
module nand_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/nand_rdy_monitor.sv
module nand_rdy_monitor #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_async,
  input  logic clr_flag,
  output logic rdy_sync,
  output logic flag
);
  logic [STAGES:0] sh_q;
  logic            rise;
  logic            flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sh_q <= '1;
    else
      sh_q <= {sh_q[STAGES-1:0], rdy_async};
  end

  assign rdy_sync = sh_q[STAGES-1];
  assign rise     = sh_q[STAGES-1] & ~sh_q[STAGES];

  always_comb begin
    flag_d = flag;
    if (rise)
      flag_d = 1'b1;
    else if (clr_flag)
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else
      flag <= flag_d;
  end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  output logic          busy,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          tim_we,
  input  logic [8*FW-1:0] tim_wdata,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_wdata,
  input  logic          ctl_we,
  input  logic [1:0]    ctl_wdata,
  output logic          stat_ready,
  output logic          irq_flag,
  output logic          irq,
  output logic          nand_ce_n,
  output logic          nand_cle,
  output logic          nand_ale,
  output logic          nand_we_n,
  output logic          nand_re_n,
  output logic          nand_wp_n,
  output logic [DW-1:0] nand_dq_o,
  output logic          nand_dq_oe,
  input  logic [DW-1:0] nand_dq_i,
  input  logic          nand_rdy
);
  localparam int TW = 8 * FW;
  localparam int CW = FW + 1;

  seq_state_t     st_q, st_d;
  logic [TW-1:0]  tim_q;
  logic           force_ce_q, wp_rel_q, irq_en_q;
  req_kind_t      kind_q;
  logic [DW-1:0]  byte_q, rd_q;
  logic           rd_vld_q, rd_vld_d;
  logic           soft_rst, flag_clr, accept, cap_rd;
  logic           sel_rd, active, cur_rd;
  logic [2:0]     grp;
  logic [FW-1:0]  f_su, f_hd, f_pw, f_rw;
  logic           t_load, t_en, t_done;
  logic [CW-1:0]  t_val;
  logic           rdy_s;

  assign soft_rst = ctl_we & ctl_wdata[0];
  assign flag_clr = ctl_we & (ctl_wdata[1] | ctl_wdata[0]);
  assign accept   = (st_q == ST_IDLE) & req_valid & ~soft_rst;
  assign cur_rd   = (kind_q == K_DRD);

  // Timing group: incoming request while idle, latched request otherwise
  assign sel_rd = (st_q == ST_IDLE) ? (req_kind_t'(req_kind) == K_DRD) : cur_rd;
  assign grp    = sel_rd ? 3'd0 : 3'(GRP_WRITE);
  assign f_su   = tim_q[(int'(grp) + SLOT_SETUP) * FW +: FW];
  assign f_hd   = tim_q[(int'(grp) + SLOT_HOLD)  * FW +: FW];
  assign f_pw   = tim_q[(int'(grp) + SLOT_PULSE) * FW +: FW];
  assign f_rw   = tim_q[(int'(grp) + SLOT_WAIT)  * FW +: FW];

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    t_load = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE: if (req_valid) begin
        st_d = ST_SETUP; t_load = 1'b1; t_val = {1'b0, f_su};
      end
      ST_SETUP: if (t_done) begin
        st_d = ST_PULSE; t_load = 1'b1; t_val = {1'b0, f_pw};
      end
      ST_PULSE: if (t_done) begin
        st_d = ST_HOLD; t_load = 1'b1; t_val = {1'b0, f_hd};
      end
      ST_HOLD: if (t_done) begin
        if (f_rw == '0) begin
          st_d = ST_IDLE;
        end else begin
          st_d = ST_RWAIT; t_load = 1'b1; t_val = {f_rw, 1'b0} - CW'(1);
        end
      end
      ST_RWAIT: if (t_done) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (soft_rst) st_d = ST_IDLE;
  end

  assign t_en     = t_load | (st_q != ST_IDLE);
  assign cap_rd   = (st_q == ST_PULSE) & t_done & cur_rd;
  assign rd_vld_d = (st_q != ST_IDLE) & (st_d == ST_IDLE) & cur_rd & ~soft_rst;

  nand_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(t_en), .load(t_load),
    .load_val(t_val), .done(t_done)
  );

  nand_rdy_monitor #(.STAGES(2)) u_rdy (
    .clk(clk), .rst_n(rst_n), .rdy_async(nand_rdy), .clr_flag(flag_clr),
    .rdy_sync(rdy_s), .flag(irq_flag)
  );

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= K_CMD;
      byte_q <= '0;
    end else if (accept) begin
      kind_q <= req_kind_t'(req_kind);
      byte_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tim_q <= '0;
    else if (tim_we) tim_q <= tim_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      force_ce_q <= 1'b0; wp_rel_q <= 1'b0; irq_en_q <= 1'b0;
    end else if (soft_rst) begin
      force_ce_q <= 1'b0; wp_rel_q <= 1'b0; irq_en_q <= 1'b0;
    end else if (cfg_we) begin
      force_ce_q <= cfg_wdata[0]; wp_rel_q <= cfg_wdata[1]; irq_en_q <= cfg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (cap_rd) rd_q <= nand_dq_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld_q <= 1'b0;
    else        rd_vld_q <= rd_vld_d;
  end

  // Bus and host outputs
  assign active     = (st_q == ST_SETUP) | (st_q == ST_PULSE) | (st_q == ST_HOLD);
  assign busy       = (st_q != ST_IDLE);
  assign nand_cle   = active & (kind_q == K_CMD);
  assign nand_ale   = active & (kind_q == K_ADDR);
  assign nand_dq_oe = active & ~cur_rd;
  assign nand_dq_o  = byte_q;
  assign nand_we_n  = ~((st_q == ST_PULSE) & ~cur_rd);
  assign nand_re_n  = ~((st_q == ST_PULSE) & cur_rd);
  assign nand_ce_n  = ~(active | force_ce_q);
  assign nand_wp_n  = wp_rel_q;
  assign rd_data    = rd_q;
  assign rd_valid   = rd_vld_q;
  assign stat_ready = rdy_s & ~busy;
  assign irq        = irq_flag & irq_en_q;
endmodule

// File: rtl/nand_bus_seq_chk.sv
module nand_bus_seq_chk #(
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          nand_we_n,
  input logic          nand_re_n,
  input logic          nand_cle,
  input logic          nand_ale,
  input logic          nand_ce_n,
  input logic          nand_dq_oe,
  input logic          rd_valid,
  input logic [8*FW-1:0] tim_q,
  input logic          force_ce,
  input logic          soft_rst
);
  localparam int RW = FW + 1;
  logic [RW-1:0] we_run, re_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run <= '0;
      re_run <= '0;
    end else begin
      we_run <= nand_we_n ? '0 : we_run + RW'(1);
      re_run <= nand_re_n ? '0 : re_run + RW'(1);
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n)); // R13
  AST_STROBE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !nand_ce_n); // R13
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale)); // R2
  AST_WE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_dq_oe); // R4
  AST_RE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (nand_we_n && nand_re_n && !nand_cle && !nand_ale)); // R7
  AST_FORCE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    force_ce |-> !nand_ce_n); // R8
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_we_n && we_run != '0 && !$past(soft_rst))
      |-> we_run == ({1'b0, tim_q[6*FW +: FW]} + RW'(1))); // R4
  AST_RE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_re_n && re_run != '0 && !$past(soft_rst))
      |-> re_run == ({1'b0, tim_q[2*FW +: FW]} + RW'(1))); // R5
endmodule

bind nand_bus_seq nand_bus_seq_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
  .nand_ce_n(nand_ce_n), .nand_dq_oe(nand_dq_oe), .rd_valid(rd_valid),
  .tim_q(tim_q), .force_ce(force_ce_q), .soft_rst(soft_rst)
);

// File: tb/tb_nand_bus_seq.sv
module tb_nand_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [7:0] req_wdata = 8'h00;
  logic busy, rd_valid, stat_ready, irq_flag, irq;
  logic [7:0] rd_data, nand_dq_o;
  logic tim_we = 1'b0;
  logic [31:0] tim_wdata = 32'h0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_wdata = 3'b000;
  logic ctl_we = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_wp_n, nand_dq_oe;
  logic [7:0] nand_dq_i = 8'h00;
  logic nand_rdy = 1'b1;

  always #5 clk = ~clk;

  nand_bus_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_wdata(req_wdata), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
    .tim_we(tim_we), .tim_wdata(tim_wdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .stat_ready(stat_ready),
    .irq_flag(irq_flag), .irq(irq), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_wp_n(nand_wp_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rdy(nand_rdy)
  );

  typedef struct {
    int kind; logic [7:0] b; int su; int lo; int tl; logic forced;
  } exp_t;
  exp_t exp_q[$];

  int total = 0;
  int bad = 0;
  logic [31:0] tim_cur = 32'h0;
  logic mon_en = 1'b1;
  logic forced = 1'b0;
  logic finished = 1'b0;

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int fld(input logic [31:0] t, input int slot);
    return int'(t[slot*4 +: 4]);
  endfunction

  task automatic set_tim(input logic [31:0] v);
    @(negedge clk); tim_we = 1'b1; tim_wdata = v;
    @(negedge clk); tim_we = 1'b0; tim_cur = v;
  endtask

  task automatic set_cfg(input logic [2:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0; forced = v[0];
  endtask

  task automatic set_ctl(input logic [1:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  // Driver: push the expected shape, then issue the request
  task automatic access(input int kind, input logic [7:0] b, input logic [7:0] dev_byte);
    exp_t e;
    int g;
    g = (kind == 3) ? 0 : 4;
    e.kind = kind; e.b = (kind == 3) ? dev_byte : b; e.forced = forced;
    e.su = fld(tim_cur, g) + 1;
    e.lo = fld(tim_cur, g + 2) + 1;
    e.tl = fld(tim_cur, g + 1) + 1 + 2 * fld(tim_cur, g + 3);
    exp_q.push_back(e);
    @(negedge clk);
    nand_dq_i = dev_byte;
    req_valid = 1'b1; req_kind = 2'(kind); req_wdata = b;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: measure each access and compare with the queued expectation
  initial begin
    int ph; int c_su; int c_lo; int c_tl; logic strobe;
    exp_t cur;
    ph = 0; c_su = 0; c_lo = 0; c_tl = 0;
    cur = '{0, 8'h00, 0, 0, 0, 1'b0};
    forever begin
      @(negedge clk);
      if (!mon_en || !rst_n) begin
        ph = 0;
      end else begin
        strobe = (cur.kind == 3) ? nand_re_n : nand_we_n;
        case (ph)
          0: if (busy) begin
            if (exp_q.size() == 0) begin
              chk(1'b0, "R7 unexpected access started", 1, 0);
              cur = '{0, 8'h00, 0, 0, 0, 1'b0};
            end else begin
              cur = exp_q.pop_front();
            end
            chk(nand_cle == (cur.kind == 0), "R2 cle level", int'(nand_cle), int'(cur.kind == 0));
            chk(nand_ale == (cur.kind == 1), "R3 ale level", int'(nand_ale), int'(cur.kind == 1));
            chk(nand_dq_oe == (cur.kind != 3), "R5 bus drive", int'(nand_dq_oe), int'(cur.kind != 3));
            chk(nand_ce_n == 1'b0, "R13 ce low in access", int'(nand_ce_n), 0);
            chk(stat_ready == 1'b0, "R9 status masked while busy", int'(stat_ready), 0);
            strobe = (cur.kind == 3) ? nand_re_n : nand_we_n;
            c_su = 1; c_lo = 0; c_tl = 0; ph = 1;
          end
          1: if (!strobe) begin
            c_lo = 1; ph = 2;
            if (cur.kind != 3)
              chk(nand_dq_o == cur.b, "R2 byte on bus", int'(nand_dq_o), int'(cur.b));
          end else c_su++;
          2: if (!strobe) c_lo++;
          else if (busy) begin c_tl = 1; ph = 3; end
          else ph = 4;
          3: if (busy) c_tl++; else ph = 4;
          default: ;
        endcase
        if (ph == 4) begin
          chk(c_su == cur.su, "R4 setup clocks", c_su, cur.su);
          chk(c_lo == cur.lo, "R4 strobe clocks", c_lo, cur.lo);
          chk(c_tl == cur.tl, "R6 hold plus ready-wait clocks", c_tl, cur.tl);
          chk(rd_valid == (cur.kind == 3), "R5 rd_valid after access", int'(rd_valid), int'(cur.kind == 3));
          if (cur.kind == 3)
            chk(rd_data == cur.b, "R5 read byte", int'(rd_data), int'(cur.b));
          chk(nand_ce_n == !cur.forced, "R13 ce after access", int'(nand_ce_n), int'(!cur.forced));
          ph = 0;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=150000 expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 ce/strobes high", int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    chk(!nand_cle && !nand_ale && !nand_dq_oe, "R1 latches/bus idle", int'({nand_cle, nand_ale, nand_dq_oe}), 0);
    chk(!busy && !rd_valid && !irq_flag && !nand_wp_n, "R1 busy/valid/flag/wp", int'({busy, rd_valid, irq_flag, nand_wp_n}), 0);
    chk(stat_ready == 1'b1, "R1 ready status", int'(stat_ready), 1);

    // Pattern A: mixed fields with write ready-wait
    set_tim(32'h2312_0401);
    access(0, 8'h70, 8'h00);   // R2
    access(1, 8'h12, 8'h00);   // R3
    access(2, 8'hA5, 8'h00);   // R3 data write
    access(3, 8'h00, 8'h3C);   // R5
    // Pattern B: all minimum, no wait
    set_tim(32'h0000_0000);
    access(2, 8'h5A, 8'h00);
    access(3, 8'h00, 8'hC3);
    access(0, 8'hFF, 8'h00);
    // Pattern C: all maximum
    set_tim(32'hFFFF_FFFF);
    access(2, 8'h81, 8'h00);
    access(3, 8'h00, 8'h7E);

    // R7: requests while busy are ignored
    set_tim(32'h1313_1313);
    begin
      exp_t e;
      e.kind = 2; e.b = 8'h44; e.forced = 1'b0;
      e.su = 4; e.lo = 4; e.tl = 2 + 2; exp_q.push_back(e);
    end
    @(negedge clk); req_valid = 1'b1; req_kind = 2'd2; req_wdata = 8'h44;
    @(negedge clk); req_kind = 2'd1; req_wdata = 8'h99;
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(!busy, "R7 no second access", int'(busy), 0);
    chk(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

    // R8 force CE, R11 write protect release
    set_cfg(3'b011);
    chk(nand_ce_n == 1'b0, "R8 forced ce idle", int'(nand_ce_n), 0);
    chk(nand_wp_n == 1'b1, "R11 wp released", int'(nand_wp_n), 1);
    access(0, 8'h90, 8'h00);
    chk(nand_ce_n == 1'b0, "R8 forced ce after access", int'(nand_ce_n), 0);
    set_cfg(3'b000);
    chk(nand_ce_n == 1'b1, "R8 ce released", int'(nand_ce_n), 1);
    chk(nand_wp_n == 1'b0, "R11 wp asserted", int'(nand_wp_n), 0);

    // R9, R10 ready status and interrupt flag
    nand_rdy = 1'b0;
    repeat (4) @(negedge clk);
    chk(stat_ready == 1'b0, "R9 busy device", int'(stat_ready), 0);
    chk(irq_flag == 1'b0, "R10 no flag on fall", int'(irq_flag), 0);
    nand_rdy = 1'b1;
    repeat (4) @(negedge clk);
    chk(stat_ready == 1'b1, "R9 ready device", int'(stat_ready), 1);
    chk(irq_flag == 1'b1, "R10 flag on rise", int'(irq_flag), 1);
    chk(irq == 1'b0, "R10 irq masked", int'(irq), 0);
    set_cfg(3'b100);
    chk(irq == 1'b1, "R10 irq enabled", int'(irq), 1);
    set_ctl(2'b10);
    chk(irq_flag == 1'b0 && irq == 1'b0, "R10 flag cleared", int'({irq_flag, irq}), 0);

    // R12 soft reset in the middle of a long access
    set_cfg(3'b111);
    nand_rdy = 1'b0; repeat (4) @(negedge clk);
    nand_rdy = 1'b1; repeat (4) @(negedge clk);
    set_tim(32'hFFFF_FFFF);
    mon_en = 1'b0;
    @(negedge clk); req_valid = 1'b1; req_kind = 2'd2; req_wdata = 8'h33;
    @(negedge clk); req_valid = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy && !nand_we_n, "R12 access in strobe before reset", int'({busy, nand_we_n}), 2);
    set_ctl(2'b01);
    chk(!busy && nand_we_n, "R12 back to idle", int'({busy, nand_we_n}), 1);
    chk(nand_wp_n == 1'b0 && irq_flag == 1'b0 && irq == 1'b0, "R12 cfg and flag cleared",
        int'({nand_wp_n, irq_flag, irq}), 0);
    chk(nand_ce_n == 1'b1, "R12 force ce cleared", int'(nand_ce_n), 1);
    forced = 1'b0;
    repeat (2) @(negedge clk);
    mon_en = 1'b1;
    set_tim(32'h0000_0000);
    access(3, 8'h00, 8'h5E);   // R12 timing kept and sequencer usable

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule